// File: doc/BRIEF.md
# Palette RAM Host Access Sequencer

This block sits between a byte-wide microprocessor bus and a 256-entry, 18-bit color lookup RAM. The host picks one of four targets with a 2-bit register select. The targets are an 8-bit address pointer (loaded in write mode or in read mode), the palette data port, and an 8-bit pixel mask register. The mask register's value is driven out to the pixel path. A hidden modulo-3 lane counter splits each 18-bit entry into red, green and blue 6-bit transfers. The address pointer advances only after the blue transfer.

Writes gather red and green in staging registers, and the RAM is written once, on blue. In read mode the addressed word is prefetched into a holding register when the pointer is loaded and again after every increment. The three byte reads are served from that register. Strobes are active-low and asynchronous to the block clock. Each access is synchronized and takes effect on the trailing (rising) edge of its strobe. The host keeps the select and data lines stable from strobe fall until three clock cycles after strobe rise, and leaves at least ten clock cycles between accesses.

The host bus is a strobe protocol with no valid/ready pair and no back-pressure: the block never stalls the host, and it meets the access spacing above within its own latency. The RAM port has no back-pressure either, because the RAM accepts a write or read request on every cycle.

Top module: `pal_host_seq`

## Requirements
- R1: The select {bus_rs[1], bus_rs[0]} decodes as 2'b00 = address pointer (load selects write mode), 2'b11 = address pointer (load selects read mode), 2'b01 = palette data, 2'b10 = pixel mask register.
- R2: A lane counter steps 0, 1, 2 (red, green, blue) on each palette data access and never holds 3. It is not visible to the host: a read of either address select returns only the 8-bit pointer.
- R3: Writing either address select loads the pointer and clears the lane counter to 0. Reading either address select changes neither the pointer, the lane counter nor the read/write mode.
- R4: A color write stages red and green without touching the RAM. On the blue write the RAM is written exactly once, at the current pointer, with word {red[17:12], green[11:6], blue[5:0]}, and the pointer increments. Non-blue accesses leave the pointer unchanged.
- R5: In read mode the word at the pointer is fetched after a read-mode load and after each increment. The three data reads return red, green, blue of that word, and the pointer increments after the blue read.
- R6: Color bytes use bus bits 5..0. Bits 7..6 are ignored on data writes and read as 0 on data reads.
- R7: A blue access at pointer FFh wraps the pointer to 00h.
- R8: If both strobes are low at the same time, the overlapping access or accesses have no effect on any register or on the RAM.
- R9: An access takes effect only after the rising edge of its strobe. Read data is driven while the strobe is low and shows the state from before the access. After reset the pointer is 00h, the lane counter is 0 and the mode is write.
- R10: The pixel mask register resets to FFh, is written and read through select 2'b10, and is driven continuously on pix_mask.
- R11: The RAM port asserts ram_re for one cycle per fetch and captures ram_rdata on the following cycle. ram_we is combined with ram_addr and ram_wdata in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| bus_rs | input | 2 | Register select |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, selected by bus_rs |
| pix_mask | output | 8 | Current pixel mask value |
| ram_addr | output | 8 | Palette RAM address |
| ram_wdata | output | 18 | Palette RAM write word |
| ram_we | output | 1 | Palette RAM write enable |
| ram_re | output | 1 | Palette RAM read request |
| ram_rdata | input | 18 | Palette RAM read word, valid one cycle after ram_re |

## Verification
The assertions check on every cycle that the lane counter stays in range and that pointer reads leave the pointer, lane and mode alone. They also check that a pointer load clears the lane and, in read mode, issues a fetch, that only blue accesses advance the pointer, and that the upper read bits of a data read are zero. Only the bench scenarios can show the actual word stored in or returned from the RAM and the red-green-blue ordering. The same holds for wrap at FFh seen from the host, the discarding of overlapped strobes, and that nothing changes before the trailing strobe edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    SEL_PTR_WR = 2'b00,
    SEL_DATA   = 2'b01,
    SEL_MASK   = 2'b10,
    SEL_PTR_RD = 2'b11
  } sel_e;

  localparam int unsigned LANES = 3;  // red, green, blue
endpackage

// File: rtl/pal_strobe_sync.sv
module pal_strobe_sync
  import pal_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_rs,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              acc_rd,
  output logic              acc_wr,
  output sel_e              acc_sel,
  output logic [DATA_W-1:0] acc_data
);
  logic [SYNC_STAGES-1:0] rd_sh, wr_sh;
  logic rd_s, wr_s, rd_s_q, wr_s_q, clash_q;

  assign rd_s = rd_sh[SYNC_STAGES-1];
  assign wr_s = wr_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sh   <= '1;
      wr_sh   <= '1;
      rd_s_q  <= 1'b1;
      wr_s_q  <= 1'b1;
      clash_q <= 1'b0;
    end else begin
      rd_sh  <= {rd_sh[SYNC_STAGES-2:0], bus_rd_n};
      wr_sh  <= {wr_sh[SYNC_STAGES-2:0], bus_wr_n};
      rd_s_q <= rd_s;
      wr_s_q <= wr_s;
      // an overlap taints every access until both strobes are released
      if (!rd_s && !wr_s)     clash_q <= 1'b1;
      else if (rd_s && wr_s)  clash_q <= 1'b0;
    end
  end

  // bus fields are captured while a synchronized strobe is still low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sel  <= SEL_PTR_WR;
      acc_data <= '0;
    end else if (!rd_s || !wr_s) begin
      acc_sel  <= sel_e'(bus_rs);
      acc_data <= bus_wdata;
    end
  end

  // trailing-edge accesses, discarded after any overlap (R8, R9)
  assign acc_rd = rd_s && !rd_s_q && wr_s && !clash_q;
  assign acc_wr = wr_s && !wr_s_q && rd_s && !clash_q;
endmodule

// File: rtl/pal_ctrl_regs.sv
module pal_ctrl_regs
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  sel_e              acc_sel,
  input  logic [DATA_W-1:0] acc_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANE_W-1:0] lane_q,
  output logic              rd_mode,
  output logic              fetch_q,
  output logic [DATA_W-1:0] mask_q
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic ptr_load, data_acc;

  assign ptr_load = acc_wr && (acc_sel == SEL_PTR_WR || acc_sel == SEL_PTR_RD);
  assign data_acc = (acc_rd || acc_wr) && acc_sel == SEL_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      lane_q  <= '0;
      rd_mode <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (ptr_load) begin
        addr_q  <= acc_data[ADDR_W-1:0];
        lane_q  <= '0;
        rd_mode <= (acc_sel == SEL_PTR_RD);
        fetch_q <= (acc_sel == SEL_PTR_RD);
      end else if (data_acc) begin
        if (lane_q == LAST_LANE) begin
          lane_q  <= '0;
          addr_q  <= addr_q + 1'b1;
          fetch_q <= rd_mode;
        end else begin
          lane_q <= lane_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             mask_q <= '1;
    else if (acc_wr && acc_sel == SEL_MASK) mask_q <= acc_data;
  end
endmodule

// File: rtl/pal_word_stage.sv
module pal_word_stage
  import pal_pkg::*;
#(
  parameter int unsigned COLOR_W = 6,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * COLOR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_wr,
  input  sel_e               acc_sel,
  input  logic [COLOR_W-1:0] acc_color,
  input  logic [LANE_W-1:0]  lane_q,
  input  logic               fetch_q,
  input  logic [WORD_W-1:0]  ram_rdata,
  output logic               ram_we,
  output logic [WORD_W-1:0]  ram_wdata,
  output logic               ram_re,
  output logic [WORD_W-1:0]  hold_q
);
  logic data_wr, re_q;
  logic [COLOR_W-1:0] stage_q [LANES-1];

  assign data_wr = acc_wr && acc_sel == SEL_DATA;

  // staging for every lane but the last; the last lane goes straight through
  for (genvar g = 0; g < LANES - 1; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  stage_q[g] <= '0;
      else if (data_wr && lane_q == LANE_W'(g))    stage_q[g] <= acc_color;
    end
    assign ram_wdata[WORD_W-1-g*COLOR_W -: COLOR_W] = stage_q[g];
  end
  assign ram_wdata[COLOR_W-1:0] = acc_color;

  assign ram_we = data_wr && lane_q == LANE_W'(LANES - 1);
  assign ram_re = fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      re_q <= ram_re;
      if (re_q) hold_q <= ram_rdata;
    end
  end
endmodule

// File: rtl/pal_host_seq.sv
module pal_host_seq
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned COLOR_W     = 6,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = LANES * COLOR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        bus_rs,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] pix_mask,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [WORD_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  input  logic [WORD_W-1:0] ram_rdata
);
  localparam int unsigned LANE_W = $clog2(LANES);

  logic              acc_rd, acc_wr, rd_mode, fetch_q;
  sel_e              acc_sel;
  logic [DATA_W-1:0] acc_data, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] hold_q;
  logic [COLOR_W-1:0] lane_byte;

  pal_strobe_sync #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk, .rst_n, .bus_rd_n, .bus_wr_n, .bus_rs, .bus_wdata,
    .acc_rd, .acc_wr, .acc_sel, .acc_data
  );

  pal_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst_n, .acc_rd, .acc_wr, .acc_sel, .acc_data,
    .addr_q, .lane_q, .rd_mode, .fetch_q, .mask_q
  );

  pal_word_stage #(.COLOR_W(COLOR_W)) u_word (
    .clk, .rst_n, .acc_wr, .acc_sel,
    .acc_color(acc_data[COLOR_W-1:0]),
    .lane_q, .fetch_q, .ram_rdata,
    .ram_we, .ram_wdata, .ram_re, .hold_q
  );

  assign ram_addr = addr_q;
  assign pix_mask = mask_q;

  always_comb begin
    lane_byte = hold_q[(WORD_W-1) - int'(lane_q) * COLOR_W -: COLOR_W];
    case (sel_e'(bus_rs))
      SEL_DATA: bus_rdata = DATA_W'(lane_byte);
      SEL_MASK: bus_rdata = mask_q;
      default:  bus_rdata = DATA_W'(addr_q);
    endcase
  end
endmodule

// File: rtl/pal_host_seq_chk.sv
module pal_host_seq_chk
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd_n,
  input logic [1:0]        bus_rs,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              acc_rd,
  input logic              acc_wr,
  input sel_e              acc_sel,
  input logic [ADDR_W-1:0] addr_q,
  input logic [LANE_W-1:0] lane_q,
  input logic              rd_mode,
  input logic              ram_we,
  input logic              ram_re
);
  logic ptr_sel, blue_acc, data_acc;
  assign ptr_sel  = acc_sel == SEL_PTR_WR || acc_sel == SEL_PTR_RD;
  assign data_acc = (acc_rd || acc_wr) && acc_sel == SEL_DATA;
  assign blue_acc = data_acc && lane_q == LANE_W'(LANES - 1);

  p_lane_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_q < LANE_W'(LANES));

  p_ptr_read_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && ptr_sel |=> $stable(addr_q) && $stable(lane_q) && $stable(rd_mode));

  p_ptr_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && ptr_sel |=> lane_q == '0);

  p_ram_write_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> addr_q == $past(addr_q) + 1'b1);

  p_non_blue_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && !blue_acc |=> $stable(addr_q));

  p_blue_read_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd && blue_acc |=> addr_q == $past(addr_q) + 1'b1);

  p_read_load_fetches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && acc_sel == SEL_PTR_RD |=> ram_re);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n && bus_rs == 2'b01 |-> bus_rdata[DATA_W-1:6] == '0);

  p_one_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr));

  p_ram_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re));
endmodule

bind pal_host_seq pal_host_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .bus_rs(bus_rs),
  .bus_rdata(bus_rdata), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_sel(acc_sel),
  .addr_q(addr_q), .lane_q(lane_q), .rd_mode(rd_mode),
  .ram_we(ram_we), .ram_re(ram_re)
);

// File: tb/pal_host_seq_bench.sv
`timescale 1ns/1ps
module pal_host_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic [1:0]  bus_rs = 2'b00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata, pix_mask, ram_addr;
  logic [17:0] ram_wdata, ram_rdata;
  logic        ram_we, ram_re;

  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = 8'h00;
  logic [17:0] poke_d = '0;
  logic [17:0] mem [256];
  int          wr_count = 0;
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  pal_host_seq u_pal_host_seq (
    .clk, .rst_n, .bus_rd_n, .bus_wr_n, .bus_rs, .bus_wdata, .bus_rdata,
    .pix_mask, .ram_addr, .ram_wdata, .ram_we, .ram_re, .ram_rdata
  );

  // palette RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wr_count <= wr_count + 1;
    end
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] rs, input logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_wdata = d; bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic hread(input logic [1:0] rs, output logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = bus_rdata;
    bus_rd_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [17:0] d);
    @(negedge clk);
    poke_a = a; poke_d = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    hread(2'b00, v); chk("R9 reset pointer", v, 8'h00);
    hread(2'b10, v); chk("R10 reset mask read", v, 8'hFF);
    chk("R10 reset pix_mask", pix_mask, 8'hFF);
  endtask

  task automatic t_write_triplet;
    logic [7:0] v;
    int base;
    hwrite(2'b00, 8'h10);
    base = wr_count;
    hwrite(2'b01, 8'h2A);
    hwrite(2'b01, 8'h15);
    chk("R4 no RAM write before blue", wr_count - base, 0);
    hwrite(2'b01, 8'h3C);
    chk("R4 one RAM write on blue", wr_count - base, 1);
    chk("R4 word layout", mem[8'h10], {6'h2A, 6'h15, 6'h3C});
    hread(2'b00, v); chk("R4 pointer step", v, 8'h11);
    hwrite(2'b01, 8'h01); hwrite(2'b01, 8'h02); hwrite(2'b01, 8'h03);
    chk("R4 next entry", mem[8'h11], {6'h01, 6'h02, 6'h03});
    hread(2'b11, v); chk("R1 read via 11 select", v, 8'h12);
  endtask

  task automatic t_upper_ignored;
    hwrite(2'b00, 8'h30);
    hwrite(2'b01, 8'hFF); hwrite(2'b01, 8'hC0); hwrite(2'b01, 8'h81);
    chk("R6 write upper bits ignored", mem[8'h30], {6'h3F, 6'h00, 6'h01});
  endtask

  task automatic t_read_keeps;
    logic [7:0] v;
    poke(8'h40, {6'h11, 6'h22, 6'h33});
    poke(8'h41, {6'h05, 6'h3E, 6'h07});
    hwrite(2'b11, 8'h40);
    hread(2'b01, v); chk("R5 red", v, 8'h11);
    hread(2'b00, v); chk("R3 pointer read mid-triplet", v, 8'h40);
    hread(2'b01, v); chk("R3 lane kept after pointer read", v, 8'h22);
    hread(2'b01, v); chk("R5 blue", v, 8'h33);
    hread(2'b11, v); chk("R5 pointer after blue read", v, 8'h41);
    hread(2'b01, v); chk("R11 prefetch after increment", v, 8'h05);
    hread(2'b01, v); chk("R6 read upper bits zero", v, 8'h3E);
  endtask

  task automatic t_ptr_write_clears;
    logic [7:0] v;
    int base;
    hwrite(2'b00, 8'h50);
    base = wr_count;
    hwrite(2'b01, 8'h01);
    hread(2'b00, v); chk("R2 lane hidden in pointer read", v, 8'h50);
    hwrite(2'b00, 8'h60);
    hwrite(2'b01, 8'h0A); hwrite(2'b01, 8'h0B); hwrite(2'b01, 8'h0C);
    chk("R3 lane cleared by pointer write", mem[8'h60], {6'h0A, 6'h0B, 6'h0C});
    chk("R3 single RAM write", wr_count - base, 1);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    hwrite(2'b00, 8'hFF);
    hwrite(2'b01, 8'h21); hwrite(2'b01, 8'h22); hwrite(2'b01, 8'h23);
    chk("R7 write at FF", mem[8'hFF], {6'h21, 6'h22, 6'h23});
    hread(2'b00, v); chk("R7 write wrap", v, 8'h00);
    poke(8'h00, {6'h19, 6'h1A, 6'h1B});
    hwrite(2'b11, 8'hFF);
    hread(2'b01, v); hread(2'b01, v); hread(2'b01, v);
    chk("R7 read blue at FF", v, 8'h23);
    hread(2'b00, v); chk("R7 read wrap", v, 8'h00);
    hread(2'b01, v); chk("R7 fetch after wrap", v, 8'h19);
  endtask

  task automatic t_clash;
    logic [7:0] v;
    int base;
    hwrite(2'b00, 8'h70);
    base = wr_count;
    @(negedge clk);
    bus_rs = 2'b10; bus_wdata = 8'h55; bus_rd_n = 1'b0; bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_rd_n = 1'b1; bus_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 mask untouched by overlap", pix_mask, 8'hFF);
    @(negedge clk);
    bus_rs = 2'b00; bus_wdata = 8'h77; bus_wr_n = 1'b0; bus_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    bus_rd_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    hread(2'b00, v); chk("R8 pointer untouched by overlap", v, 8'h70);
    chk("R8 no RAM write", wr_count - base, 0);
  endtask

  task automatic t_mask_edge;
    logic [7:0] v;
    @(negedge clk);
    bus_rs = 2'b10; bus_wdata = 8'h0F; bus_wr_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 no effect while strobe low", pix_mask, 8'hFF);
    bus_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 effect after trailing edge", pix_mask, 8'h0F);
    hread(2'b10, v); chk("R10 mask read back", v, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_triplet();
    t_upper_ignored();
    t_read_keeps();
    t_ptr_write_clears();
    t_wrap();
    t_clash();
    t_mask_edge();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule